// File: doc/BRIEF.md
# Hashed Flow Sequence Tagger

This block sits at a switch input port. Each arriving fixed-size cell names the output it is headed for and carries a flow key made of a 32-bit source address and a 32-bit destination address. On acceptance the block stamps the cell with one or more 10-bit sequence numbers and advances the counters that supplied them. The output side can then restore order within a group of flows that share a counter, without holding back cells of unrelated flows.

Each output owns a bank of M counters. A static mode input picks how that bank is used. In single-counter mode every cell to an output shares counter 0. In hashed mode one hash of the flow key selects one counter. In multi-hash mode K different hashes each select a counter, and the cell carries all K values. The tag is taken from the counter state in the cycle the cell is accepted. The increment is written at the same clock edge, so back-to-back cells to one counter get consecutive numbers with no stall.

The block is a pass-through on the valid/ready path. The tagged cell appears in the same cycle as the input cell, and acceptance follows the downstream ready signal.

Top module: `fst_tagger`

## Requirements
- R1: While reset is asserted, and until it has been released for two clock edges, out_valid and in_ready are 0. All counters start at 0, so the first cell that uses a counter receives the value 0.
- R2: Once out of reset, in_ready equals out_ready and out_valid equals in_valid. out_dest and out_data equal in_dest and in_data in the same cycle. A cell is accepted in a cycle where in_valid and in_ready are both 1.
- R3: With tag_mode 0 (single counter), and also with the spare code 3, only lane 0 is active (out_lanes = 1), its index is 0, and each accepted cell to an output receives the next value of that output's single counter.
- R4: With tag_mode 1 (hashed), only lane 0 is active. Its index is hash 0 of the key, and its value is the current value of that counter of the destination output. Inactive lanes report index 0 and value 0. Flows whose hashes coincide share one sequence, exactly as in single-counter mode.
- R5: With tag_mode 2 (multi-hash), all K lanes are active. Lane j reports index h_j and the current value of counter h_j of the destination output, and every selected counter is advanced on acceptance.
- R6: Hash lane j rotates the destination address left by r_j = 1 + ((7j+4) mod 31) bits, XORs the result with the source address, and multiplies by C_j = (0x9E3779B1 + j*0x7F4A7C16 mod 2^32) OR 1, modulo 2^32. The top log2(M) bits of the product are the counter index. Lane j occupies out_idx[j*log2(M) +: log2(M)] and out_seq[j*10 +: 10].
- R7: If two active lanes of one cell select the same counter, both report the same value, and that counter advances by exactly one.
- R8: Counters are 10 bits wide and wrap from 1023 to 0.
- R9: A cell that is presented but not accepted leaves every counter unchanged.
- R10: Counters of different outputs are independent. A cell to one output never changes the sequence seen by another output.
- R11: Cells accepted on consecutive cycles that use the same counter receive consecutive values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tag_mode | input | 2 | 0 single counter, 1 hashed, 2 multi-hash, 3 same as 0 |
| in_valid | input | 1 | Input cell valid |
| in_ready | output | 1 | Input cell accepted when high together with in_valid |
| in_dest | input | log2(N_OUT) | Destination output index |
| in_src | input | 32 | Flow key: source address |
| in_dst | input | 32 | Flow key: destination address |
| in_data | input | DATA_W | Cell payload |
| out_valid | output | 1 | Tagged cell valid |
| out_ready | input | 1 | Downstream can take the tagged cell |
| out_dest | output | log2(N_OUT) | Destination output index |
| out_data | output | DATA_W | Cell payload |
| out_lanes | output | K | Active tag lanes |
| out_idx | output | K*log2(M) | Counter index per lane |
| out_seq | output | K*10 | Sequence value per lane |

## Verification
A counter that advanced wrongly, whether it was missed on acceptance, bumped during a stall, or bumped twice for a repeated index, shows on the very next cell that selects that counter. That cell's value then differs from the reference by one or more. A hash that maps to the wrong index shows in the same cycle on out_idx, and usually also as a value from the wrong counter. A leak between outputs shows as a jump in another output's sequence at its next cell. The reference model is updated and compared every clock, so each fault surfaces at the first port-visible cell after it happens.

// File: rtl/fst_pkg.sv
package fst_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_HASH1  = 2'd1,
    MODE_HASHK  = 2'd2,
    MODE_SPARE  = 2'd3
  } tag_mode_e;

  // Odd multiplier used by hash lane j.
  function automatic logic [31:0] lane_mult(input int j);
    logic [31:0] base;
    base = 32'h9E37_79B1 + (32'(j) * 32'h7F4A_7C16);
    return base | 32'h1;
  endfunction

  // Rotation amount of hash lane j, always within 1..31.
  function automatic int lane_rot(input int j);
    return 1 + ((7 * j + 4) % 31);
  endfunction

endpackage

// File: rtl/fst_rst_sync.sv
module fst_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/fst_hash_lane.sv
module fst_hash_lane #(
  parameter int LANE  = 0,
  parameter int IDX_W = 3
) (
  input  logic [31:0]      src_i,
  input  logic [31:0]      dst_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [31:0] MULT = fst_pkg::lane_mult(LANE);
  localparam int          ROT  = fst_pkg::lane_rot(LANE);

  logic [31:0] rot_d;
  logic [31:0] mixed;
  logic [31:0] prod;

  always_comb begin
    rot_d = (dst_i << ROT) | (dst_i >> (32 - ROT));
    mixed = src_i ^ rot_d;
    prod  = mixed * MULT;
    idx_o = IDX_W'(prod >> (32 - IDX_W));
  end
endmodule

// File: rtl/fst_lane_sel.sv
module fst_lane_sel #(
  parameter int K     = 3,
  parameter int IDX_W = 3
) (
  input  fst_pkg::tag_mode_e   mode_i,
  input  logic [K*IDX_W-1:0]   hash_idx_i,
  output logic [K-1:0]         act_o,
  output logic [K*IDX_W-1:0]   idx_o
);
  always_comb begin
    act_o = K'(1);
    idx_o = '0;
    case (mode_i)
      fst_pkg::MODE_HASH1: begin
        idx_o[IDX_W-1:0] = hash_idx_i[IDX_W-1:0];
      end
      fst_pkg::MODE_HASHK: begin
        act_o = '1;
        idx_o = hash_idx_i;
      end
      default: begin
        act_o = K'(1);
        idx_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/fst_ctr_bank.sv
module fst_ctr_bank #(
  parameter int N_OUT  = 4,
  parameter int M      = 8,
  parameter int K      = 3,
  parameter int SEQ_W  = 10,
  parameter int DEST_W = 2,
  parameter int IDX_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire_i,
  input  logic [DEST_W-1:0]    dest_i,
  input  logic [K-1:0]         act_i,
  input  logic [K*IDX_W-1:0]   idx_i,
  output logic [K*SEQ_W-1:0]   val_o
);
  localparam int DEPTH = N_OUT * M;
  localparam int AW    = DEST_W + IDX_W;

  logic [SEQ_W-1:0] cnt_q [DEPTH];
  logic [SEQ_W-1:0] cnt_d [DEPTH];
  logic [DEPTH-1:0] hit;
  logic [AW-1:0]    addr [K];

  for (genvar j = 0; j < K; j++) begin : g_addr
    assign addr[j] = {dest_i, idx_i[j*IDX_W +: IDX_W]};
    assign val_o[j*SEQ_W +: SEQ_W] = act_i[j] ? cnt_q[addr[j]] : '0;
  end

  // A counter named by several lanes of one cell is hit once.
  always_comb begin
    hit = '0;
    for (int c = 0; c < DEPTH; c++) begin
      for (int j = 0; j < K; j++) begin
        if (fire_i && act_i[j] && (addr[j] == AW'(c))) hit[c] = 1'b1;
      end
      cnt_d[c] = cnt_q[c] + SEQ_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < DEPTH; c++) cnt_q[c] <= '0;
    end else begin
      for (int c = 0; c < DEPTH; c++) begin
        if (hit[c]) cnt_q[c] <= cnt_d[c];
      end
    end
  end
endmodule

// File: rtl/fst_tagger.sv
module fst_tagger #(
  parameter int N_OUT  = 4,
  parameter int M      = 8,
  parameter int K      = 3,
  parameter int SEQ_W  = 10,
  parameter int DATA_W = 32,
  localparam int DEST_W = $clog2(N_OUT),
  localparam int IDX_W  = $clog2(M)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           tag_mode,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DEST_W-1:0]    in_dest,
  input  logic [31:0]          in_src,
  input  logic [31:0]          in_dst,
  input  logic [DATA_W-1:0]    in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DEST_W-1:0]    out_dest,
  output logic [DATA_W-1:0]    out_data,
  output logic [K-1:0]         out_lanes,
  output logic [K*IDX_W-1:0]   out_idx,
  output logic [K*SEQ_W-1:0]   out_seq
);
  logic               rst_n_s;
  logic               fire;
  logic [K*IDX_W-1:0] hash_idx;
  logic [K-1:0]       lane_act;
  logic [K*IDX_W-1:0] lane_idx;

  fst_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  assign in_ready  = out_ready & rst_n_s;
  assign out_valid = in_valid & rst_n_s;
  assign fire      = in_valid & in_ready;

  for (genvar j = 0; j < K; j++) begin : g_hash
    fst_hash_lane #(.LANE(j), .IDX_W(IDX_W)) u_hash (
      .src_i (in_src),
      .dst_i (in_dst),
      .idx_o (hash_idx[j*IDX_W +: IDX_W])
    );
  end

  fst_lane_sel #(.K(K), .IDX_W(IDX_W)) u_sel (
    .mode_i     (fst_pkg::tag_mode_e'(tag_mode)),
    .hash_idx_i (hash_idx),
    .act_o      (lane_act),
    .idx_o      (lane_idx)
  );

  fst_ctr_bank #(
    .N_OUT(N_OUT), .M(M), .K(K), .SEQ_W(SEQ_W), .DEST_W(DEST_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .fire_i (fire),
    .dest_i (in_dest),
    .act_i  (lane_act),
    .idx_i  (lane_idx),
    .val_o  (out_seq)
  );

  assign out_lanes = lane_act;
  assign out_idx   = lane_idx;
  assign out_dest  = in_dest;
  assign out_data  = in_data;
endmodule

// File: rtl/fst_tagger_chk.sv
module fst_tagger_chk #(
  parameter int K      = 3,
  parameter int SEQ_W  = 10,
  parameter int DEST_W = 2,
  parameter int IDX_W  = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           tag_mode,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [DEST_W-1:0]    in_dest,
  input logic [31:0]          in_src,
  input logic [31:0]          in_dst,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [K-1:0]         out_lanes,
  input logic [K*IDX_W-1:0]   out_idx,
  input logic [K*SEQ_W-1:0]   out_seq
);
  logic dup_bad;
  logic acc_single;

  always_comb begin
    dup_bad = 1'b0;
    for (int a = 0; a < K; a++) begin
      for (int b = a + 1; b < K; b++) begin
        if (out_lanes[a] && out_lanes[b] &&
            out_idx[a*IDX_W +: IDX_W] == out_idx[b*IDX_W +: IDX_W] &&
            out_seq[a*SEQ_W +: SEQ_W] != out_seq[b*SEQ_W +: SEQ_W])
          dup_bad = 1'b1;
      end
    end
  end

  assign acc_single = in_valid && in_ready && (tag_mode == 2'd0);

  // R2
  ready_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready);

  // R3
  single_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (tag_mode == 2'd0 || tag_mode == 2'd3)) |-> (out_lanes == K'(1) && out_idx == '0));

  // R4
  hash1_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && tag_mode == 2'd1) |-> ($countones(out_lanes) == 1 && out_lanes[0]));

  // R5
  hashk_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && tag_mode == 2'd2) |-> (out_lanes == '1));

  // R7
  shared_index_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !dup_bad);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (!($stable(in_src) && $stable(in_dst) && $stable(in_dest) && $stable(tag_mode)) || $stable(out_seq)));

  // R11
  single_consecutive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_single |=>
      (!(acc_single && in_dest == $past(in_dest)) ||
       out_seq[SEQ_W-1:0] == SEQ_W'($past(out_seq[SEQ_W-1:0]) + 1'b1)));
endmodule

bind fst_tagger fst_tagger_chk #(
  .K(K), .SEQ_W(SEQ_W), .DEST_W(DEST_W), .IDX_W(IDX_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tag_mode  (tag_mode),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_dest   (in_dest),
  .in_src    (in_src),
  .in_dst    (in_dst),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_lanes (out_lanes),
  .out_idx   (out_idx),
  .out_seq   (out_seq)
);

// File: tb/fst_tagger_tb_top.sv
`timescale 1ns/1ps
module fst_tagger_tb_top;
  localparam int N_OUT = 4, M = 8, K = 3, SEQ_W = 10, DATA_W = 32;
  localparam int DEST_W = $clog2(N_OUT), IDX_W = $clog2(M);

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] tag_mode;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [DEST_W-1:0] in_dest, out_dest;
  logic [31:0] in_src, in_dst;
  logic [DATA_W-1:0] in_data, out_data;
  logic [K-1:0] out_lanes;
  logic [K*IDX_W-1:0] out_idx;
  logic [K*SEQ_W-1:0] out_seq;

  always #2.5 clk = ~clk;

  fst_tagger #(.N_OUT(N_OUT), .M(M), .K(K), .SEQ_W(SEQ_W), .DATA_W(DATA_W)) dut_i (.*);

  int checks = 0, errors = 0;
  bit live = 0;
  bit done = 0;
  string phase_tag = "R1";
  int mcnt [N_OUT][M];
  bit pend_fire = 0;
  int pend_dest;
  int pend_idx [K];
  bit pend_act [K];
  int dup_seen = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int bh(input int j, input logic [31:0] s, input logic [31:0] d);
    int r;
    logic [31:0] c, x;
    logic [63:0] p;
    r = 1 + ((7 * j + 4) % 31);
    c = 32'(32'h9E3779B1 + 32'(j) * 32'h7F4A7C16) | 32'd1;
    x = s ^ ((d << r) | (d >> (32 - r)));
    p = {32'd0, x} * {32'd0, c};
    return int'(p[31:0] >> (32 - IDX_W));
  endfunction

  // Reference comparison away from the active edge.
  always @(negedge clk) begin
    if (live) begin
      int e_idx [K];
      bit e_act [K];
      int d;
      bit dup;
      string tag;
      d = int'(in_dest);
      for (int j = 0; j < K; j++) begin
        e_act[j] = (tag_mode == 2'd2) || (j == 0);
        e_idx[j] = 0;
        if (tag_mode == 2'd2 || (tag_mode == 2'd1 && j == 0)) e_idx[j] = bh(j, in_src, in_dst);
      end
      dup = 0;
      for (int a = 0; a < K; a++)
        for (int b = a + 1; b < K; b++)
          if (e_act[a] && e_act[b] && e_idx[a] == e_idx[b]) dup = 1;
      case (tag_mode)
        2'd1: tag = "R4 R6";
        2'd2: tag = "R5 R6";
        default: tag = "R3";
      endcase
      tag = {tag, " ", phase_tag, dup ? " R7" : ""};
      chk(in_ready == out_ready, "R2", "in_ready", in_ready, out_ready);
      chk(out_valid == in_valid, "R2", "out_valid", out_valid, in_valid);
      if (in_valid) begin
        if (dup && in_ready) dup_seen++;
        chk(out_data == in_data && out_dest == in_dest, "R2", "pass-through data", out_data, in_data);
        for (int j = 0; j < K; j++) begin
          int ev;
          ev = e_act[j] ? mcnt[d][e_idx[j]] : 0;
          chk(out_lanes[j] == e_act[j], tag, $sformatf("lane%0d active", j), out_lanes[j], e_act[j]);
          chk(int'(out_idx[j*IDX_W +: IDX_W]) == e_idx[j], tag, $sformatf("lane%0d index", j),
              out_idx[j*IDX_W +: IDX_W], e_idx[j]);
          chk(int'(out_seq[j*SEQ_W +: SEQ_W]) == ev, tag, $sformatf("lane%0d seq", j),
              out_seq[j*SEQ_W +: SEQ_W], ev);
        end
      end
      pend_fire = in_valid && out_ready;
      pend_dest = d;
      for (int j = 0; j < K; j++) begin
        pend_idx[j] = e_idx[j];
        pend_act[j] = e_act[j];
      end
    end
  end

  always @(posedge clk) begin
    if (live && pend_fire) begin
      for (int c = 0; c < M; c++) begin
        bit h;
        h = 0;
        for (int j = 0; j < K; j++) if (pend_act[j] && pend_idx[j] == c) h = 1;
        if (h) mcnt[pend_dest][c] = (mcnt[pend_dest][c] + 1) % 1024;
      end
      pend_fire = 0;
    end
  end

  task automatic cyc(input int mode, input int dest, input logic [31:0] s, input logic [31:0] d,
                     input bit v, input bit r);
    @(posedge clk);
    #1;
    tag_mode  = 2'(mode);
    in_dest   = DEST_W'(dest);
    in_src    = s;
    in_dst    = d;
    in_valid  = v;
    out_ready = r;
    in_data   = $urandom;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] fs [8];
    logic [31:0] fd [8];
    logic [31:0] ks, kd;
    bit found;
    for (int o = 0; o < N_OUT; o++) for (int c = 0; c < M; c++) mcnt[o][c] = 0;
    rst_n = 0; tag_mode = 0; in_valid = 1; out_ready = 1;
    in_dest = 0; in_src = 0; in_dst = 0; in_data = 0;
    // R1: nothing passes while in reset
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      chk(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    end
    in_valid = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    live = 1;

    // R1 R11: first cells from zero, back to back
    phase_tag = "R1 R11";
    for (int i = 0; i < 6; i++) cyc(0, 0, $urandom, $urandom, 1, 1);
    // R10: mixed outputs in single mode, spare code too
    phase_tag = "R10 R11";
    for (int i = 0; i < 60; i++) cyc((i % 5 == 0) ? 3 : 0, $urandom_range(0, N_OUT - 1), $urandom, $urandom, 1, 1);
    // R8: run one output past the wrap
    phase_tag = "R8";
    for (int i = 0; i < 1030; i++) cyc(0, 1, $urandom, $urandom, 1, 1);
    // R4 R9: hashed flows with stalls and gaps
    for (int f = 0; f < 8; f++) begin fs[f] = $urandom; fd[f] = $urandom; end
    phase_tag = "R9";
    for (int i = 0; i < 150; i++) begin
      int f;
      f = $urandom_range(0, 7);
      cyc(1, $urandom_range(0, N_OUT - 1), fs[f], fd[f], $urandom_range(0, 4) != 0, $urandom_range(0, 3) != 0);
    end
    // R5: multi-hash with stalls
    phase_tag = "R9 R10";
    for (int i = 0; i < 200; i++) begin
      int f;
      f = $urandom_range(0, 7);
      cyc(2, $urandom_range(0, N_OUT - 1), fs[f], fd[f], $urandom_range(0, 4) != 0, $urandom_range(0, 3) != 0);
    end
    // R7: key whose first two hashes coincide
    found = 0;
    ks = 0; kd = 0;
    for (int t = 0; t < 10000 && !found; t++) begin
      ks = $urandom; kd = $urandom;
      if (bh(0, ks, kd) == bh(1, ks, kd)) found = 1;
    end
    phase_tag = "R7";
    for (int i = 0; i < 5; i++) cyc(2, 2, ks, kd, 1, 1);
    cyc(2, 2, ks, kd, 0, 1);
    @(negedge clk);
    chk(dup_seen >= 5, "R7", "shared-index cells accepted", dup_seen, 5);
    live = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule